// File: doc/BRIEF.md
# Programmable NAND-Term Control Array

This block turns a bundle of routed control inputs into the per-cell control lines for a group of sixteen I/O cells. Each of the 32 inputs is offered to the array in both polarities, which gives 64 literals. Twenty product terms each pick any subset of those literals through a static connection mask and form the NAND of the literals they pick.

Twelve of the terms drive control outputs directly. The remaining eight are grouped into four fixed pairs, and each pair is ORed into one dedicated output that serves as a set, reset or output-enable line. The connection masks are static configuration presented on an input port. The block has no storage: every output follows its inputs combinationally.

Top module: `ctrl_nand_array`

## Requirements
- R1: Mask bit t*64+2i connects the true form of sig_i[i] to term t, and mask bit t*64+2i+1 connects the complement of sig_i[i] to term t.
- R2: A term with a non-empty mask reads 0 when every literal it selects is 1, and reads 1 otherwise.
- R3: A term whose mask is all zero reads 0. With the whole configuration at zero, every output is 0.
- R4: A term that selects both the true and complement forms of the same input reads 1 for any input values.
- R5: ctrl_o[j] for j in 0..11 equals term j+8.
- R6: ctrl_o[12+k] for k in 0..3 equals the OR of terms 2k and 2k+1.
- R7: Inputs that a term does not select have no effect on that term's value.
- R8: A single term can select all 32 true literals and then acts as a 32-input NAND.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sig_i | input | 32 | Routed control inputs |
| term_mask_i | input | 1280 | Static connection masks, 64 bits per term, term t at bits t*64 +: 64 |
| ctrl_o | output | 16 | Control outputs: 0..11 direct terms, 12..15 ORed pairs |

## Verification
The assertions check on every evaluation that an unprogrammed term is inactive and that a term holding both polarities of one input is stuck active. They also check that every paired output is at least as high as each of its two terms, and that outputs fed only by empty terms stay low. The bench scenarios are needed to show the literal polarity encoding, the exact term-to-output mapping, the insensitivity to unselected inputs and the full-width NAND. The bench compares all sixteen outputs against an independent loop-based model over directed and sparse random configurations.

// File: rtl/ctrl_nand_array.sv
module ctrl_nand_array #(
  parameter int N_IN   = 32,
  parameter int N_TERM = 20,
  parameter int N_OUT  = 16
) (
  input  logic [N_IN-1:0]          sig_i,
  input  logic [N_TERM*2*N_IN-1:0] term_mask_i,
  output logic [N_OUT-1:0]         ctrl_o
);
  localparam int N_LIT      = 2 * N_IN;
  localparam int N_PAIR     = N_TERM - N_OUT;
  localparam int N_DIRECT   = N_OUT - N_PAIR;
  localparam int PAIR_TERMS = 2 * N_PAIR;

  logic [N_LIT-1:0]  lit;
  logic [N_TERM-1:0] term;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit[2*i]   = sig_i[i];
    assign lit[2*i+1] = ~sig_i[i];
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [N_LIT-1:0] m;
    logic             clash;
    assign m       = term_mask_i[t*N_LIT +: N_LIT];
    assign term[t] = ~&(lit | ~m);

    always_comb begin
      clash = 1'b0;
      for (int i = 0; i < N_IN; i++) clash = clash | (m[2*i] & m[2*i+1]);
    end

    // R3: an unprogrammed term never asserts
    always_comb begin
      if (m == '0) p_empty_term_low_r3: assert (term[t] == 1'b0);
    end

    // R4: opposite polarities of one input make the product impossible
    always_comb begin
      if (clash) p_clash_term_high_r4: assert (term[t] == 1'b1);
    end
  end

  for (genvar j = 0; j < N_DIRECT; j++) begin : g_direct
    assign ctrl_o[j] = term[PAIR_TERMS+j];

    // R5: a direct output fed by an empty term stays low
    always_comb begin
      if (term_mask_i[(PAIR_TERMS+j)*N_LIT +: N_LIT] == '0)
        p_direct_empty_low_r5: assert (ctrl_o[j] == 1'b0);
    end
  end

  for (genvar k = 0; k < N_PAIR; k++) begin : g_pair
    assign ctrl_o[N_DIRECT+k] = term[2*k] | term[2*k+1];

    // R6: a paired output is high whenever either of its terms is high
    always_comb begin
      p_pair_covers_r6: assert ((ctrl_o[N_DIRECT+k] >= term[2*k]) &&
                                (ctrl_o[N_DIRECT+k] >= term[2*k+1]));
    end

    // R6: both terms unprogrammed leaves the paired output low
    always_comb begin
      if (term_mask_i[2*k*N_LIT +: 2*N_LIT] == '0)
        p_pair_empty_low_r6: assert (ctrl_o[N_DIRECT+k] == 1'b0);
    end
  end
endmodule

// File: tb/ctrl_nand_array_tb_top.sv
module ctrl_nand_array_tb_top;
  localparam int NI = 32;
  localparam int NT = 20;
  localparam int NO = 16;
  localparam int NL = 2 * NI;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NI-1:0]     sig;
  logic [NT*NL-1:0]  mask;
  logic [NO-1:0]     ctrl;
  int                n_chk = 0;
  int                n_bad = 0;
  bit                done  = 1'b0;

  always #5 clk = ~clk;

  ctrl_nand_array dut_i (.sig_i(sig), .term_mask_i(mask), .ctrl_o(ctrl));

  function automatic logic [NO-1:0] model(input logic [NI-1:0] s, input logic [NT*NL-1:0] m);
    logic [NT-1:0] tv;
    logic [NO-1:0] o;
    for (int t = 0; t < NT; t++) begin
      logic prod = 1'b1;
      for (int i = 0; i < NI; i++) begin
        if (m[t*NL+2*i])   prod = prod & s[i];
        if (m[t*NL+2*i+1]) prod = prod & ~s[i];
      end
      tv[t] = ~prod;
    end
    for (int j = 0; j < 12; j++) o[j] = tv[8+j];
    for (int k = 0; k < 4; k++)  o[12+k] = tv[2*k] | tv[2*k+1];
    return o;
  endfunction

  task automatic drive(input logic [NI-1:0] s);
    @(negedge clk);
    sig = s;
    #1;
  endtask

  task automatic check_bit(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [NO-1:0] exp;
    exp = model(sig, mask);
    n_chk++;
    if (ctrl !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, ctrl, exp);
    end
  endtask

  task automatic sel(input int t, input int litidx);
    mask[t*NL+litidx] = 1'b1;
  endtask

  task automatic t_reset_state;
    mask = '0;
    drive('0);
    check_bit("R3 zero config, inputs 0", |ctrl, 1'b0);
    drive('1);
    check_bit("R3 zero config, inputs 1", |ctrl, 1'b0);
  endtask

  task automatic t_polarity;
    mask = '0;
    sel(8, 2*5);
    sel(9, 2*5+1);
    drive(32'h0000_0020);
    check_bit("R1 R2 R5 true literal, in=1", ctrl[0], 1'b0);
    check_bit("R1 R2 R5 complement literal, in=1", ctrl[1], 1'b1);
    drive(32'h0000_0000);
    check_bit("R1 R2 R5 true literal, in=0", ctrl[0], 1'b1);
    check_bit("R1 R2 R5 complement literal, in=0", ctrl[1], 1'b0);
    check_bit("R3 unused direct output", ctrl[2], 1'b0);
  endtask

  task automatic t_clash;
    mask = '0;
    sel(19, 2*7);
    sel(19, 2*7+1);
    drive(32'h0000_0080);
    check_bit("R4 clash term, in=1", ctrl[11], 1'b1);
    drive(32'h0000_0000);
    check_bit("R4 clash term, in=0", ctrl[11], 1'b1);
  endtask

  task automatic t_pairs;
    mask = '0;
    sel(0, 0);
    sel(1, 2);
    sel(6, 4);
    for (int v = 0; v < 8; v++) begin
      logic a, b, c;
      {c, b, a} = v[2:0];
      drive({29'b0, c, b, a});
      check_bit("R6 pair 0 OR", ctrl[12], ~a | ~b);
      check_bit("R6 pair 3 with empty partner", ctrl[15], ~c);
      check_bit("R6 empty pair 1", ctrl[13], 1'b0);
    end
  endtask

  task automatic t_ignore;
    mask = '0;
    sel(9, 2*3);
    sel(9, 2*4+1);
    drive(32'h0000_0008);
    check_bit("R7 selected literals satisfied", ctrl[1], 1'b0);
    drive(32'hFFFF_FFE7 | 32'h0000_0008);
    check_bit("R7 other inputs flipped", ctrl[1], 1'b0);
    drive(32'hA5A5_A5A5 & ~32'h0000_0010 | 32'h0000_0008);
    check_bit("R7 mixed other inputs", ctrl[1], 1'b0);
    check_all("R7 full compare");
  endtask

  task automatic t_wide;
    mask = '0;
    for (int i = 0; i < NI; i++) sel(8, 2*i);
    drive('1);
    check_bit("R8 wide NAND all ones", ctrl[0], 1'b0);
    drive(32'h7FFF_FFFF);
    check_bit("R8 wide NAND msb low", ctrl[0], 1'b1);
    drive(32'hFFFF_FFFE);
    check_bit("R8 wide NAND lsb low", ctrl[0], 1'b1);
  endtask

  task automatic t_random;
    for (int it = 0; it < 300; it++) begin
      mask = '0;
      for (int t = 0; t < NT; t++) begin
        int n = $urandom_range(0, 3);
        for (int q = 0; q < n; q++) sel(t, $urandom_range(0, NL-1));
      end
      drive($urandom);
      check_all("R2 R5 R6 random sparse");
    end
  endtask

  initial begin
    sig  = '0;
    mask = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_polarity();
    t_clash();
    t_pairs();
    t_ignore();
    t_wide();
    t_random();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1ms;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule